// File: doc/BRIEF.md
# Stack Control-Transfer Sequencer

This block runs the bus cycles of the stack-based control transfers in a 6502-family CPU that has a 16-bit native mode and an 8-bit emulation mode. It handles exception entry, whether from the break or coprocessor opcodes or from a hardware request (IRQ, NMI, ABORT), and it handles the three return instructions: return-from-interrupt, return-from-subroutine and return-long. The core's decoder pulses `start` with the opcode, or with a hardware request code, plus the current PC, program bank, status flags, stack pointer and mode flag. From then on the block drives exactly one bus cycle per clock.

Each bus cycle is one of four kinds: an internal IO cycle, a stack push, a stack pull, or a vector byte read. Memory is a single-port bus outside the block. Read data is sampled on the clock edge that ends the cycle. When the last cycle finishes, the block raises `done` for one cycle. During that cycle the outputs carry the new PC, program bank, flags and stack pointer, and the core loads them. In native mode the program-bank byte is pushed or pulled as part of the sequence. In emulation mode that byte is skipped wherever the sequence calls for it, and the stack pointer is confined to page one.

Top module: `stack_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done` and `busWe` are all 0.
- R2: A `start` is accepted only while the block is idle and the request is recognised. A `start` with `hwReq`=0 and an opcode outside the five listed in R12 is ignored: `busy` and `done` stay 0. A `start` raised while a sequence is running changes nothing in that sequence.
- R3: Every sequence begins with two IO cycles (`busCycle`=0) addressed at {PBR,PC} as latched. Exception entry then pushes the bank byte (native mode only), the PC high byte, the PC low byte and the flags, and then reads the vector low byte and the vector high byte. This gives 8 cycles in native mode and 7 in emulation mode.
- R4: A push (`busCycle`=1, `busWe`=1) writes at address {0x00,S} and then decrements S. For the break and coprocessor opcodes the pushed PC is the opcode address plus 2. For hardware requests it is the opcode address.
- R5: A vector read (`busCycle`=3) fetches the low byte at V and the high byte at V+1, where V is in bank 0. In native mode V is 0xFFE6 for break, 0xFFE4 for coprocessor, 0xFFEE for IRQ, 0xFFEA for NMI and 0xFFE8 for ABORT. In emulation mode V is 0xFFFE for break and IRQ, 0xFFF4 for coprocessor, 0xFFFA for NMI and 0xFFF8 for ABORT.
- R6: After exception entry, the result PC is {high,low} read from the vector, PBR is 0, P is the input P with bit 2 set, and S is the pointer after the pushes.
- R7: Return-from-interrupt runs two IO cycles, then pulls the flags, PC low byte, PC high byte and, in native mode only, the bank byte. The result loads P and PC unchanged from the pulled bytes. PBR is loaded from the pulled bank byte in native mode and is left unchanged in emulation mode.
- R8: Return-from-subroutine runs two IO cycles, then pulls the PC low byte and PC high byte, then runs one IO cycle addressed at {0x00,S}. The result PC is the pulled value plus 1, modulo 2^16. PBR and P are unchanged.
- R9: Return-long runs two IO cycles, then pulls the PC low byte, PC high byte and bank byte in both modes. The result PC is the pulled value plus 1, and PBR is the pulled bank byte.
- R10: A pull (`busCycle`=2) first increments S and then reads at {0x00,S}. In emulation mode the high byte of S is forced to 0x01 on load and after every step, so the low byte wraps within page one.
- R11: `done` is high for exactly one cycle, the cycle right after the last bus cycle. The result outputs are valid in that cycle, and `busy` is 0 in it.
- R12: The opcodes are 0x00 break, 0x02 coprocessor, 0x40 return-from-interrupt, 0x60 return-from-subroutine and 0x6B return-long. `hwReq` is encoded as 0 none, 1 IRQ, 2 NMI and 3 ABORT. A nonzero `hwReq` takes precedence over the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer sequence |
| opcode | input | 8 | Decoded opcode, used when hwReq is 0 |
| hwReq | input | 2 | Hardware exception code |
| emuIn | input | 1 | Emulation-mode flag |
| pcIn | input | 16 | Current PC (opcode address) |
| pbrIn | input | 8 | Current program bank |
| pIn | input | 8 | Current status flags |
| spIn | input | 16 | Current stack pointer |
| busRdata | input | 8 | Read data, sampled at the end of the cycle |
| busAddr | output | 24 | Bus address for this cycle |
| busWe | output | 1 | Write strobe (push cycles) |
| busWdata | output | 8 | Write data |
| busCycle | output | 2 | Cycle kind: 0 IO, 1 push, 2 pull, 3 vector |
| busy | output | 1 | A bus cycle of a sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| pcOut | output | 16 | Resulting PC |
| pbrOut | output | 8 | Resulting program bank |
| pOut | output | 8 | Resulting status flags |
| spOut | output | 16 | Resulting stack pointer |

## Verification
The assertions assume three things about the inputs. Request fields are only sampled on an accepted `start`. The core waits for `done` before it issues another request. Read data is valid by the end of each pull or vector cycle. The stimulus meets these assumptions by having a behavioural memory answer every read address on the falling edge, and by waiting for the idle cycle after `done` before each new request. The one deliberate breach is holding `start` high, with a different opcode, for the whole of a running sequence. This checks that a running sequence ignores a new request.

// File: rtl/stack_xfer_pkg.sv
package stack_xfer_pkg;
  localparam int DATA_W = 8;
  localparam int PC_W   = 16;

  typedef enum logic [1:0] {CYC_IO = 2'd0, CYC_PUSH = 2'd1, CYC_PULL = 2'd2, CYC_VEC = 2'd3} cycKind_e;
  typedef enum logic [1:0] {XC_EXC, XC_RTI, XC_RTS, XC_RTL} xferClass_e;
  typedef enum logic [1:0] {BS_BANK, BS_HI, BS_LO, BS_FLAGS} byteSel_e;
  typedef enum logic [2:0] {EX_BRK, EX_COP, EX_IRQ, EX_NMI, EX_ABORT} excSrc_e;

  localparam logic [7:0] OPC_BRK = 8'h00;
  localparam logic [7:0] OPC_COP = 8'h02;
  localparam logic [7:0] OPC_RTI = 8'h40;
  localparam logic [7:0] OPC_RTS = 8'h60;
  localparam logic [7:0] OPC_RTL = 8'h6B;

  typedef struct packed {
    logic       load;
    logic       active;
    cycKind_e   kind;
    byteSel_e   sel;
    logic       stkIo;
  } stepCtl_t;

  function automatic logic [PC_W-1:0] vecOf(input logic emu, input excSrc_e src);
    logic [PC_W-1:0] v;
    if (emu) begin
      unique case (src)
        EX_COP:   v = 16'hFFF4;
        EX_NMI:   v = 16'hFFFA;
        EX_ABORT: v = 16'hFFF8;
        default:  v = 16'hFFFE;
      endcase
    end else begin
      unique case (src)
        EX_BRK:   v = 16'hFFE6;
        EX_COP:   v = 16'hFFE4;
        EX_NMI:   v = 16'hFFEA;
        EX_ABORT: v = 16'hFFE8;
        default:  v = 16'hFFEE;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/stack_xfer_ctrl.sv
module stack_xfer_ctrl
  import stack_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       reqOk,
  input  xferClass_e cls,
  input  logic       emu,
  output stepCtl_t   ctl,
  output logic       busy,
  output logic       done
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_IO1, ST_IO2, ST_PSH_BANK, ST_PSH_HI, ST_PSH_LO, ST_PSH_FLAGS,
    ST_VEC_LO, ST_VEC_HI, ST_PUL_FLAGS, ST_PUL_LO, ST_PUL_HI, ST_PUL_BANK,
    ST_IO_STK, ST_FIN
  } state_e;

  state_e st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:      if (start && reqOk) nxt = ST_IO1;
      ST_IO1:       nxt = ST_IO2;
      ST_IO2: begin
        unique case (cls)
          XC_EXC:  nxt = emu ? ST_PSH_HI : ST_PSH_BANK;
          XC_RTI:  nxt = ST_PUL_FLAGS;
          default: nxt = ST_PUL_LO;
        endcase
      end
      ST_PSH_BANK:  nxt = ST_PSH_HI;
      ST_PSH_HI:    nxt = ST_PSH_LO;
      ST_PSH_LO:    nxt = ST_PSH_FLAGS;
      ST_PSH_FLAGS: nxt = ST_VEC_LO;
      ST_VEC_LO:    nxt = ST_VEC_HI;
      ST_VEC_HI:    nxt = ST_FIN;
      ST_PUL_FLAGS: nxt = ST_PUL_LO;
      ST_PUL_LO:    nxt = ST_PUL_HI;
      ST_PUL_HI: begin
        unique case (cls)
          XC_RTI:  nxt = emu ? ST_FIN : ST_PUL_BANK;
          XC_RTS:  nxt = ST_IO_STK;
          default: nxt = ST_PUL_BANK;
        endcase
      end
      ST_PUL_BANK:  nxt = ST_FIN;
      ST_IO_STK:    nxt = ST_FIN;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    ctl        = '0;
    ctl.load   = (st == ST_IDLE) && start && reqOk;
    ctl.active = (st != ST_IDLE) && (st != ST_FIN);
    unique case (st)
      ST_PSH_BANK:  begin ctl.kind = CYC_PUSH; ctl.sel = BS_BANK;  end
      ST_PSH_HI:    begin ctl.kind = CYC_PUSH; ctl.sel = BS_HI;    end
      ST_PSH_LO:    begin ctl.kind = CYC_PUSH; ctl.sel = BS_LO;    end
      ST_PSH_FLAGS: begin ctl.kind = CYC_PUSH; ctl.sel = BS_FLAGS; end
      ST_VEC_LO:    begin ctl.kind = CYC_VEC;  ctl.sel = BS_LO;    end
      ST_VEC_HI:    begin ctl.kind = CYC_VEC;  ctl.sel = BS_HI;    end
      ST_PUL_FLAGS: begin ctl.kind = CYC_PULL; ctl.sel = BS_FLAGS; end
      ST_PUL_LO:    begin ctl.kind = CYC_PULL; ctl.sel = BS_LO;    end
      ST_PUL_HI:    begin ctl.kind = CYC_PULL; ctl.sel = BS_HI;    end
      ST_PUL_BANK:  begin ctl.kind = CYC_PULL; ctl.sel = BS_BANK;  end
      ST_IO_STK:    begin ctl.kind = CYC_IO;   ctl.stkIo = 1'b1;   end
      default:      ctl.kind = CYC_IO;
    endcase
  end

  assign busy = ctl.active;
  assign done = (st == ST_FIN);

  // Checking logic: counts the bus cycles of the current sequence.
  logic [3:0] stepCnt;
  logic [3:0] expLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          stepCnt <= '0;
    else if (ctl.load)  stepCnt <= '0;
    else if (ctl.active) stepCnt <= stepCnt + 4'd1;
  end
  always_comb begin
    unique case (cls)
      XC_EXC:  expLen = emu ? 4'd7 : 4'd8;
      XC_RTI:  expLen = emu ? 4'd5 : 4'd6;
      default: expLen = 4'd5;
    endcase
  end

  AST_SEQ_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> stepCnt == expLen); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R11
endmodule

// File: rtl/stack_xfer_dp.sv
module stack_xfer_dp
  import stack_xfer_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic [7:0]        opcode,
  input  logic [1:0]        hwReq,
  input  logic              emuIn,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [7:0]        pbrIn,
  input  logic [7:0]        pIn,
  input  logic [PC_W-1:0]   spIn,
  input  logic [DATA_W-1:0] busRdata,
  output logic              reqOk,
  output xferClass_e        cls,
  output logic              emu,
  output logic [23:0]       busAddr,
  output logic              busWe,
  output logic [DATA_W-1:0] busWdata,
  output logic [1:0]        busCycle,
  output logic [PC_W-1:0]   pcOut,
  output logic [7:0]        pbrOut,
  output logic [7:0]        pOut,
  output logic [PC_W-1:0]   spOut
);
  localparam logic [PC_W-1:0] SW_SKIP = 16'd2;

  xferClass_e      clsD;
  excSrc_e         srcD;
  logic            swD;

  always_comb begin
    reqOk = 1'b1;
    clsD  = XC_EXC;
    srcD  = EX_IRQ;
    swD   = 1'b0;
    unique case (hwReq)
      2'd1: srcD = EX_IRQ;
      2'd2: srcD = EX_NMI;
      2'd3: srcD = EX_ABORT;
      default: begin
        unique case (opcode)
          OPC_BRK: begin srcD = EX_BRK; swD = 1'b1; end
          OPC_COP: begin srcD = EX_COP; swD = 1'b1; end
          OPC_RTI: clsD = XC_RTI;
          OPC_RTS: clsD = XC_RTS;
          OPC_RTL: clsD = XC_RTL;
          default: reqOk = 1'b0;
        endcase
      end
    endcase
  end

  logic [PC_W-1:0] pcR, spR, vecPtr;
  logic [7:0]      pbrR, pR, bufLo, bufHi, bufBank, bufFlags;
  logic            swR;

  logic [PC_W-1:0] spInc, spDec, pushPc, pulledPc;
  assign spInc    = emu ? {STACK_PAGE, spR[7:0] + 8'd1} : spR + 16'd1;
  assign spDec    = emu ? {STACK_PAGE, spR[7:0] - 8'd1} : spR - 16'd1;
  assign pushPc   = swR ? pcR + SW_SKIP : pcR;
  assign pulledPc = {bufHi, bufLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR <= '0; spR <= '0; vecPtr <= '0; pbrR <= '0; pR <= '0;
      bufLo <= '0; bufHi <= '0; bufBank <= '0; bufFlags <= '0;
      swR <= 1'b0; emu <= 1'b0; cls <= XC_EXC;
    end else if (ctl.load) begin
      pcR    <= pcIn;
      pbrR   <= pbrIn;
      pR     <= pIn;
      spR    <= emuIn ? {STACK_PAGE, spIn[7:0]} : spIn;
      vecPtr <= vecOf(emuIn, srcD);
      swR    <= swD;
      emu    <= emuIn;
      cls    <= clsD;
    end else if (ctl.active) begin
      unique case (ctl.kind)
        CYC_PUSH: spR <= spDec;
        CYC_PULL: begin
          spR <= spInc;
          unique case (ctl.sel)
            BS_FLAGS: bufFlags <= busRdata;
            BS_LO:    bufLo    <= busRdata;
            BS_HI:    bufHi    <= busRdata;
            default:  bufBank  <= busRdata;
          endcase
        end
        CYC_VEC: begin
          if (ctl.sel == BS_LO) begin
            bufLo  <= busRdata;
            vecPtr <= vecPtr + 16'd1;
          end else begin
            bufHi  <= busRdata;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (ctl.kind)
      CYC_PUSH: busAddr = {8'h00, spR};
      CYC_PULL: busAddr = {8'h00, spInc};
      CYC_VEC:  busAddr = {8'h00, vecPtr};
      default:  busAddr = ctl.stkIo ? {8'h00, spR} : {pbrR, pcR};
    endcase
    unique case (ctl.sel)
      BS_BANK: busWdata = pbrR;
      BS_HI:   busWdata = pushPc[15:8];
      BS_LO:   busWdata = pushPc[7:0];
      default: busWdata = pR;
    endcase
  end

  assign busWe    = ctl.active && (ctl.kind == CYC_PUSH);
  assign busCycle = ctl.kind;

  always_comb begin
    spOut = spR;
    unique case (cls)
      XC_EXC: begin pcOut = pulledPc; pbrOut = 8'h00; pOut = pR | 8'h04; end
      XC_RTI: begin pcOut = pulledPc; pbrOut = emu ? pbrR : bufBank; pOut = bufFlags; end
      XC_RTS: begin pcOut = pulledPc + 16'd1; pbrOut = pbrR; pOut = pR; end
      default: begin pcOut = pulledPc + 16'd1; pbrOut = bufBank; pOut = pR; end
    endcase
  end

  AST_STACK_PAGE1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && emu && (ctl.kind == CYC_PUSH || ctl.kind == CYC_PULL))
      |-> busAddr[15:8] == STACK_PAGE); // R10
  AST_VEC_ADJACENT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && ctl.kind == CYC_VEC && ctl.sel == BS_HI)
      |-> busAddr == $past(busAddr) + 24'd1); // R5
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && ctl.kind == CYC_PUSH)
      |=> spR[7:0] == $past(spR[7:0]) - 8'd1); // R4
endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq
  import stack_xfer_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [1:0]  hwReq,
  input  logic        emuIn,
  input  logic [15:0] pcIn,
  input  logic [7:0]  pbrIn,
  input  logic [7:0]  pIn,
  input  logic [15:0] spIn,
  input  logic [7:0]  busRdata,
  output logic [23:0] busAddr,
  output logic        busWe,
  output logic [7:0]  busWdata,
  output logic [1:0]  busCycle,
  output logic        busy,
  output logic        done,
  output logic [15:0] pcOut,
  output logic [7:0]  pbrOut,
  output logic [7:0]  pOut,
  output logic [15:0] spOut
);
  stepCtl_t   ctl;
  logic       reqOk, emuQ;
  xferClass_e clsQ;

  stack_xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reqOk(reqOk), .cls(clsQ),
    .emu(emuQ), .ctl(ctl), .busy(busy), .done(done)
  );

  stack_xfer_dp #(.STACK_PAGE(STACK_PAGE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opcode(opcode), .hwReq(hwReq),
    .emuIn(emuIn), .pcIn(pcIn), .pbrIn(pbrIn), .pIn(pIn), .spIn(spIn),
    .busRdata(busRdata), .reqOk(reqOk), .cls(clsQ), .emu(emuQ),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busCycle(busCycle),
    .pcOut(pcOut), .pbrOut(pbrOut), .pOut(pOut), .spOut(spOut)
  );
endmodule

// File: tb/stack_xfer_seq_bench.sv
module stack_xfer_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'hEA;
  logic [1:0]  hwReq = 2'd0;
  logic        emuIn = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0]  pbrIn = '0;
  logic [7:0]  pIn = '0;
  logic [15:0] spIn = '0;
  logic [7:0]  busRdata = '0;
  logic [23:0] busAddr;
  logic        busWe, busy, done;
  logic [7:0]  busWdata, pbrOut, pOut;
  logic [1:0]  busCycle;
  logic [15:0] pcOut, spOut;

  always #10 clk = ~clk;

  stack_xfer_seq u_stack_xfer_seq (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .hwReq(hwReq),
    .emuIn(emuIn), .pcIn(pcIn), .pbrIn(pbrIn), .pIn(pIn), .spIn(spIn),
    .busRdata(busRdata), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busCycle(busCycle), .busy(busy), .done(done), .pcOut(pcOut),
    .pbrOut(pbrOut), .pOut(pOut), .spOut(spOut)
  );

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  byte unsigned mem[int];
  byte unsigned refMem[int];
  int    qAddr[$];
  int    qWe[$];
  int    qData[$];
  int    qCyc[$];
  string qTag[$];
  int    expPc, expPbr, expP, expSp;
  string doneTag;

  task automatic chk(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int rm(input int a);
    return refMem.exists(a) ? int'(refMem[a]) : 0;
  endfunction

  function automatic int spDn(input int s, input bit em);
    return em ? (16'h0100 | ((s - 1) & 8'hFF)) : ((s - 1) & 16'hFFFF);
  endfunction

  function automatic int spUp(input int s, input bit em);
    return em ? (16'h0100 | ((s + 1) & 8'hFF)) : ((s + 1) & 16'hFFFF);
  endfunction

  function automatic int vecFor(input int op, input int hw, input bit em);
    if (hw == 1) return em ? 16'hFFFE : 16'hFFEE;
    if (hw == 2) return em ? 16'hFFFA : 16'hFFEA;
    if (hw == 3) return em ? 16'hFFF8 : 16'hFFE8;
    if (op == 8'h02) return em ? 16'hFFF4 : 16'hFFE4;
    return em ? 16'hFFFE : 16'hFFE6;
  endfunction

  task automatic addOp(input int a, input int we, input int d, input int c, input string t);
    qAddr.push_back(a); qWe.push_back(we); qData.push_back(d);
    qCyc.push_back(c); qTag.push_back(t);
  endtask

  // Behavioural reference: builds the expected bus cycles and results.
  task automatic model(input int op, input int hw, input bit em,
                       input int pc, input int pbr, input int p, input int sp);
    int s, v, pp, lo, hi, bk, fl;
    s = em ? (16'h0100 | (sp & 8'hFF)) : sp;
    addOp((pbr << 16) | pc, 0, 0, 0, "R3");
    addOp((pbr << 16) | pc, 0, 0, 0, "R3");
    if (hw != 0 || op == 8'h00 || op == 8'h02) begin
      pp = (hw != 0) ? pc : ((pc + 2) & 16'hFFFF);
      if (!em) begin addOp(s, 1, pbr, 1, "R4"); refMem[s] = 8'(pbr); s = spDn(s, em); end
      addOp(s, 1, pp >> 8, 1, "R4");   refMem[s] = 8'(pp >> 8); s = spDn(s, em);
      addOp(s, 1, pp & 8'hFF, 1, "R4"); refMem[s] = 8'(pp);     s = spDn(s, em);
      addOp(s, 1, p, 1, "R4 R10");      refMem[s] = 8'(p);      s = spDn(s, em);
      v = vecFor(op, hw, em);
      addOp(v, 0, 0, 3, "R5");
      addOp(v + 1, 0, 0, 3, "R5");
      expPc = (rm(v + 1) << 8) | rm(v); expPbr = 0; expP = p | 4; expSp = s;
      doneTag = "R6 R12";
    end else if (op == 8'h40) begin
      s = spUp(s, em); addOp(s, 0, 0, 2, "R7 R10"); fl = rm(s);
      s = spUp(s, em); addOp(s, 0, 0, 2, "R7 R10"); lo = rm(s);
      s = spUp(s, em); addOp(s, 0, 0, 2, "R7 R10"); hi = rm(s);
      bk = pbr;
      if (!em) begin s = spUp(s, em); addOp(s, 0, 0, 2, "R7"); bk = rm(s); end
      expPc = (hi << 8) | lo; expPbr = bk; expP = fl; expSp = s;
      doneTag = "R7 R12";
    end else if (op == 8'h60) begin
      s = spUp(s, em); addOp(s, 0, 0, 2, "R8 R10"); lo = rm(s);
      s = spUp(s, em); addOp(s, 0, 0, 2, "R8 R10"); hi = rm(s);
      addOp(s, 0, 0, 0, "R8");
      expPc = (((hi << 8) | lo) + 1) & 16'hFFFF; expPbr = pbr; expP = p; expSp = s;
      doneTag = "R8 R12";
    end else begin
      s = spUp(s, em); addOp(s, 0, 0, 2, "R9 R10"); lo = rm(s);
      s = spUp(s, em); addOp(s, 0, 0, 2, "R9 R10"); hi = rm(s);
      s = spUp(s, em); addOp(s, 0, 0, 2, "R9 R10"); bk = rm(s);
      expPc = (((hi << 8) | lo) + 1) & 16'hFFFF; expPbr = bk; expP = p; expSp = s;
      doneTag = "R9 R12";
    end
  endtask

  // Called on a falling edge; returns on the falling edge after the idle check.
  task automatic xfer(input int op, input int hw, input bit em, input int pc,
                      input int pbr, input int p, input int sp, input bit holdStart);
    model(op, hw, em, pc, pbr, p, sp);
    opcode = 8'(op); hwReq = 2'(hw); emuIn = em; pcIn = 16'(pc);
    pbrIn = 8'(pbr); pIn = 8'(p); spIn = 16'(sp); start = 1'b1;
    @(negedge clk);
    if (holdStart) begin opcode = 8'h60; hwReq = 2'd0; end
    else start = 1'b0;
    while (qAddr.size() > 0) begin
      string t;
      t = qTag.pop_front();
      chk({t, " busy"}, int'(busy), 1);
      chk({t, " addr"}, int'(busAddr), qAddr[0]);
      chk({t, " cycle"}, int'(busCycle), qCyc[0]);
      chk({t, " we"}, int'(busWe), qWe[0]);
      if (qWe[0] != 0) begin
        chk({t, " wdata"}, int'(busWdata), qData[0]);
        mem[int'(busAddr)] = busWdata;
      end
      busRdata = mem.exists(int'(busAddr)) ? mem[int'(busAddr)] : 8'h00;
      void'(qAddr.pop_front()); void'(qWe.pop_front()); void'(qData.pop_front());
      void'(qCyc.pop_front());
      @(negedge clk);
    end
    start = 1'b0;
    chk("R11 done", int'(done), 1);
    chk("R11 busy low at done", int'(busy), 0);
    chk({doneTag, " pc"}, int'(pcOut), expPc);
    chk({doneTag, " pbr"}, int'(pbrOut), expPbr);
    chk({doneTag, " p"}, int'(pOut), expP);
    chk({doneTag, " sp"}, int'(spOut), expSp);
    @(negedge clk);
    chk("R11 done pulse width", int'(done), 0);
    chk("R11 idle after done", int'(busy), 0);
  endtask

  initial begin
    for (int a = 16'hFFE0; a <= 16'hFFFF; a++) begin
      mem[a] = 8'((a * 7 + 3) & 8'hFF);
      refMem[a] = mem[a];
    end
    for (int a = 16'h2001; a <= 16'h2003; a++) begin
      mem[a] = 8'(a * 13 + 1); refMem[a] = mem[a];
    end
    for (int a = 16'h01FD; a <= 16'h01FF; a++) begin
      mem[a] = 8'(a * 5 + 9); refMem[a] = mem[a];
    end
    mem[16'h0100] = 8'hFF; refMem[16'h0100] = 8'hFF;

    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 we", int'(busWe), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: unrecognised opcode is ignored
    opcode = 8'hEA; hwReq = 2'd0; start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 ignored busy", int'(busy), 0);
      chk("R2 ignored done", int'(done), 0);
      chk("R2 ignored we", int'(busWe), 0);
    end
    start = 1'b0;
    @(negedge clk);

    // Native break then return-from-interrupt round trip
    xfer(8'h00, 0, 0, 16'h1234, 8'h05, 8'h30, 16'h01F0, 0);
    xfer(8'h40, 0, 0, 16'h4000, 8'h00, 8'h34, expSp, 0);
    chk("R7 round trip pc", expPc, 16'h1236);
    // Emulation break with page wrap, then return
    xfer(8'h00, 0, 1, 16'hC010, 8'h00, 8'h20, 16'h0100, 0);
    xfer(8'h40, 0, 1, 16'hF000, 8'h00, 8'h24, expSp, 0);
    // Coprocessor and hardware requests, both modes (R12 precedence: opcode 0x40 present)
    xfer(8'h02, 0, 0, 16'h8000, 8'h12, 8'h01, 16'h1FFF, 0);
    xfer(8'h40, 1, 0, 16'h9000, 8'h7E, 8'h00, 16'h3000, 0);
    xfer(8'h40, 2, 0, 16'h9100, 8'h01, 8'h80, 16'h3000, 0);
    xfer(8'h60, 3, 0, 16'h9200, 8'h02, 8'h40, 16'h3000, 0);
    xfer(8'h02, 0, 1, 16'hA000, 8'h00, 8'h10, 16'h01C0, 0);
    xfer(8'hEA, 1, 1, 16'hA100, 8'h00, 8'h10, 16'h01C0, 0);
    xfer(8'hEA, 2, 1, 16'hA200, 8'h00, 8'h10, 16'h01C0, 0);
    xfer(8'hEA, 3, 1, 16'hA300, 8'h00, 8'h10, 16'h01C0, 0);
    // Subroutine and long returns
    xfer(8'h60, 0, 0, 16'h5000, 8'h03, 8'h11, 16'h2000, 0);
    xfer(8'h6B, 0, 0, 16'h5000, 8'h03, 8'h11, 16'h2000, 0);
    xfer(8'h60, 0, 1, 16'h5000, 8'h00, 8'h11, 16'h01FD, 0);
    xfer(8'h6B, 0, 1, 16'h5000, 8'h00, 8'h11, 16'h01FD, 0);
    // R2: start held high with another opcode during a running sequence
    xfer(8'h6B, 0, 0, 16'h6000, 8'h09, 8'h22, 16'h2000, 1);
    xfer(8'h00, 0, 0, 16'hFFFF, 8'hFE, 8'h00, 16'h0000, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule